// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Split Accumulator

This block is an execution unit for a 64-bit integer core. It holds one 64-bit accumulator, kept as a high word and a low word. Each valid cycle it takes a decoded instruction word and two 32-bit source operands. It forms a signed or unsigned 64-bit product of the operands and folds that product into the accumulator in one of four ways: the accumulator is loaded with the product, loaded with its negation, has the product added, or has the product subtracted.

In the same operation, one 32-bit half of the updated accumulator goes back to a general register. That half is sign-extended to the core's register width. The destination index, write data and write enable are registered and appear one cycle after the operation is presented. An instruction word that matches none of the defined encodings raises an illegal flag for that cycle and changes nothing else. The register file, hazard logic and exception handling live outside this block.

Top module: `mac_hilo_unit`

## Requirements
- R1: A synchronous active-high reset clears both accumulator halves to zero and holds `wb_en` and `illegal` low.
- R2: An instruction is decoded only when bits [31:26] are 000000. Bits [15:11] give the destination index, bits [10:6] the sub-operation and bits [5:0] the function. `wb_idx` carries bits [15:11] of the accepted instruction.
- R3: With function bit 0 clear (functions 011000 and 101000), both 32-bit operands are sign-extended to 64 bits before multiplying.
- R4: With function bit 0 set (functions 011001 and 101001), both operands are zero-extended to 64 bits before multiplying.
- R5: Load form: sub-operation 00001 (low half) or 01001 (high half) with function 011000 or 011001 makes the accumulator equal to the product.
- R6: Negate form: sub-operation 00011 (low) or 01011 (high) with function 011000 or 011001 makes the accumulator equal to zero minus the product.
- R7: Add form: sub-operation 00010 (low) or 01010 (high) with function 101000 or 101001 adds the product to the accumulator.
- R8: Subtract form: sub-operation 00111 (low) or 01111 (high) with function 011000 or 011001 subtracts the product from the accumulator.
- R9: `wb_data` is the low 32 bits (sub-operation bit 3 clear) or high 32 bits (bit 3 set) of the accumulator after this instruction's update, sign-extended to 64 bits.
- R10: All accumulator arithmetic wraps modulo 2^64, with no saturation.
- R11: Any other instruction word with `in_valid` high sets `illegal` for one cycle, keeps `wb_en` low and leaves the accumulator unchanged.
- R12: An accepted operation shows `wb_en`, `wb_idx` and `wb_data` in the cycle after it is presented. Back-to-back operations each build on the previous update. A cycle without `in_valid` produces no write and no flag, and leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | First source operand |
| rt_val | input | 32 | Second source operand |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 64 | Sign-extended half of the updated accumulator |
| wb_en | output | 1 | Register write enable, one cycle |
| illegal | output | 1 | Unrecognised encoding, one cycle |

## Verification
The bound checker watches, on every cycle, several properties:
- the write enable and the illegal flag never rise together;
- the accumulator holds on idle and illegal cycles;
- the destination index follows the instruction;
- the write data is a sign-extended copy of the half picked by sub-operation bit 3;
- a nonzero primary opcode always raises the illegal flag.

The arithmetic itself can only be shown by the bench's scenarios. These cover signed versus unsigned extension, each of the four update forms, wrap-around, and the chaining of updates across consecutive operations. The bench compares the returned halves against a model of the accumulator built from the requirements.

// File: rtl/mac_hilo_pkg.sv
package mac_hilo_pkg;

   // Ways the accumulator is updated from the product
   typedef enum logic [1:0] {
      UPD_LOAD = 2'd0,
      UPD_NEG  = 2'd1,
      UPD_ADD  = 2'd2,
      UPD_SUB  = 2'd3
   } upd_e;

   typedef struct packed {
      logic       legal;
      logic       is_signed;
      upd_e       upd;
      logic       hi_sel;
      logic [4:0] rd;
   } dec_t;

   // Field positions inside the instruction word
   localparam int OPC_LSB = 26;
   localparam int RD_LSB  = 11;
   localparam int SUB_LSB = 6;

   // Function-field families; bit 0 selects unsigned
   localparam logic [4:0] FN_MULFAM = 5'b01100;
   localparam logic [4:0] FN_MACFAM = 5'b10100;

   // Sub-operation codes with the half-select bit (bit 3) removed: {sub[4], sub[2:0]}
   localparam logic [3:0] SUBB_LOAD = 4'b0001;
   localparam logic [3:0] SUBB_NEG  = 4'b0011;
   localparam logic [3:0] SUBB_SUB  = 4'b0111;
   localparam logic [3:0] SUBB_ADD  = 4'b0010;

endpackage

// File: rtl/mac_hilo_dec.sv
module mac_hilo_dec
   import mac_hilo_pkg::*;
(
   input  logic [31:0] instr,
   output dec_t        dec
);

   logic [5:0] opc;
   logic [4:0] sub;
   logic [5:0] fn;
   logic [3:0] sub_base;
   logic       fam_mul;
   logic       fam_mac;
   logic       hit;
   upd_e       upd_sel;
   logic       unused_regs;

   assign opc      = instr[OPC_LSB +: 6];
   assign sub      = instr[SUB_LSB +: 5];
   assign fn       = instr[5:0];
   assign sub_base = {sub[4], sub[2:0]};
   assign fam_mul  = (fn[5:1] == FN_MULFAM);
   assign fam_mac  = (fn[5:1] == FN_MACFAM);

   // Source register fields are resolved by the register file, not here
   assign unused_regs = ^instr[25:16];

   always_comb begin
      hit     = 1'b0;
      upd_sel = UPD_LOAD;
      unique case (sub_base)
         SUBB_LOAD: begin hit = fam_mul; upd_sel = UPD_LOAD; end
         SUBB_NEG:  begin hit = fam_mul; upd_sel = UPD_NEG;  end
         SUBB_SUB:  begin hit = fam_mul; upd_sel = UPD_SUB;  end
         SUBB_ADD:  begin hit = fam_mac; upd_sel = UPD_ADD;  end
         default:   begin hit = 1'b0;    upd_sel = UPD_LOAD; end
      endcase
   end

   always_comb begin
      dec.legal     = (opc == 6'b000000) && hit;
      dec.is_signed = ~fn[0];
      dec.upd       = upd_sel;
      dec.hi_sel    = sub[3];
      dec.rd        = instr[RD_LSB +: 5];
   end

endmodule

// File: rtl/mac_hilo_mul.sv
module mac_hilo_mul #(
   parameter int OP_W     = 32,
   parameter int LANE_W   = 16,
   parameter int MUL_IMPL = 1
) (
   input  logic [OP_W-1:0]   a,
   input  logic [OP_W-1:0]   b,
   input  logic              is_signed,
   output logic [2*OP_W-1:0] prod
);

   localparam int EW = 2 * OP_W;
   localparam int NL = EW / LANE_W;

   if (LANE_W < 1 || LANE_W > OP_W || (EW % LANE_W) != 0) begin : g_bad_lane
      $error("mac_hilo_mul: LANE_W must divide 2*OP_W and not exceed OP_W");
   end
   if (MUL_IMPL != 0 && MUL_IMPL != 1) begin : g_bad_impl
      $error("mac_hilo_mul: MUL_IMPL must be 0 or 1");
   end

   logic [EW-1:0] ea;
   logic [EW-1:0] eb;

   // Extension to full width; product modulo 2^EW then equals the exact product
   assign ea = is_signed ? {{OP_W{a[OP_W-1]}}, a} : {{OP_W{1'b0}}, a};
   assign eb = is_signed ? {{OP_W{b[OP_W-1]}}, b} : {{OP_W{1'b0}}, b};

   if (MUL_IMPL == 0) begin : g_direct
      assign prod = ea * eb;
   end else begin : g_lanes
      logic [EW-1:0] pp [NL][NL];
      logic [EW-1:0] sum;

      for (genvar i = 0; i < NL; i++) begin : g_row
         for (genvar j = 0; j < NL; j++) begin : g_col
            if (i + j < NL) begin : g_term
               localparam int SH = (i + j) * LANE_W;
               logic [2*LANE_W-1:0] p_ij;
               logic [EW-1:0]       pz;
               assign p_ij = ea[i*LANE_W +: LANE_W] * eb[j*LANE_W +: LANE_W];
               assign pz   = EW'(p_ij);
               assign pp[i][j] = pz << SH;
            end else begin : g_drop
               // Lands entirely above bit EW-1: vanishes modulo 2^EW
               assign pp[i][j] = '0;
            end
         end
      end

      always_comb begin
         sum = '0;
         for (int i = 0; i < NL; i++) begin
            for (int j = 0; j < NL; j++) begin
               sum = sum + pp[i][j];
            end
         end
      end

      assign prod = sum;
   end

endmodule

// File: rtl/mac_hilo_upd.sv
module mac_hilo_upd
   import mac_hilo_pkg::*;
#(
   parameter int ACC_W = 64
) (
   input  logic [ACC_W-1:0] acc,
   input  logic [ACC_W-1:0] prod,
   input  upd_e             upd,
   output logic [ACC_W-1:0] acc_nxt
);

   // All forms wrap modulo 2^ACC_W
   always_comb begin
      unique case (upd)
         UPD_LOAD: acc_nxt = prod;
         UPD_NEG:  acc_nxt = {ACC_W{1'b0}} - prod;
         UPD_ADD:  acc_nxt = acc + prod;
         UPD_SUB:  acc_nxt = acc - prod;
         default:  acc_nxt = acc;
      endcase
   end

endmodule

// File: rtl/mac_hilo_unit.sv
module mac_hilo_unit
   import mac_hilo_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int OP_W     = 32,
   parameter int LANE_W   = 16,
   parameter int MUL_IMPL = 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [31:0]     instr,
   input  logic [OP_W-1:0] rs_val,
   input  logic [OP_W-1:0] rt_val,
   output logic [4:0]      wb_idx,
   output logic [XLEN-1:0] wb_data,
   output logic            wb_en,
   output logic            illegal
);

   localparam int ACC_W = 2 * OP_W;
   localparam int EXT_W = XLEN - OP_W;

   if (XLEN <= OP_W) begin : g_bad_xlen
      $error("mac_hilo_unit: XLEN must exceed OP_W");
   end

   dec_t             dec;
   logic [ACC_W-1:0] prod;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_nxt;
   logic [OP_W-1:0]  half;
   logic             take;
   logic             reject;

   mac_hilo_dec u_dec (
      .instr (instr),
      .dec   (dec)
   );

   mac_hilo_mul #(
      .OP_W     (OP_W),
      .LANE_W   (LANE_W),
      .MUL_IMPL (MUL_IMPL)
   ) u_mul (
      .a         (rs_val),
      .b         (rt_val),
      .is_signed (dec.is_signed),
      .prod      (prod)
   );

   mac_hilo_upd #(
      .ACC_W (ACC_W)
   ) u_upd (
      .acc     (acc_q),
      .prod    (prod),
      .upd     (dec.upd),
      .acc_nxt (acc_nxt)
   );

   assign take   = in_valid &  dec.legal;
   assign reject = in_valid & ~dec.legal;

   // The returned half is taken from the post-update accumulator
   assign half = dec.hi_sel ? acc_nxt[ACC_W-1:OP_W] : acc_nxt[OP_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q   <= '0;
         wb_en   <= 1'b0;
         illegal <= 1'b0;
         wb_idx  <= '0;
         wb_data <= '0;
      end else begin
         wb_en   <= take;
         illegal <= reject;
         if (take) begin
            acc_q   <= acc_nxt;
            wb_idx  <= dec.rd;
            wb_data <= {{EXT_W{half[OP_W-1]}}, half};
         end
      end
   end

endmodule

// File: rtl/mac_hilo_chk.sv
module mac_hilo_chk #(
   parameter int XLEN = 64,
   parameter int OP_W = 32
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic [31:0]         instr,
   input logic [4:0]          wb_idx,
   input logic [XLEN-1:0]     wb_data,
   input logic                wb_en,
   input logic                illegal,
   input logic [2*OP_W-1:0]   acc
);

   // R1: first cycle out of reset is quiet with a cleared accumulator
   a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!wb_en && !illegal && acc == '0));

   // R11: a write and an illegal flag never coincide
   a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(wb_en && illegal));

   // R11: the accumulator holds across a rejected instruction
   a_r11_acc_hold: assert property (@(posedge clk) disable iff (rst)
      (illegal && !$past(rst)) |-> acc == $past(acc));

   // R2/R11: a nonzero primary opcode is always rejected
   a_r2_bad_opcode: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid) && $past(instr[31:26]) != 6'b0)
      |-> (illegal && !wb_en));

   // R2: destination index follows the accepted instruction
   a_r2_dest_idx: assert property (@(posedge clk) disable iff (rst)
      wb_en |-> wb_idx == $past(instr[15:11]));

   // R12: no valid input, no result and no accumulator change
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(in_valid))
      |-> (!wb_en && !illegal && acc == $past(acc)));

   // R9: write data is sign-extended
   a_r9_sign_ext: assert property (@(posedge clk) disable iff (rst)
      wb_en |-> wb_data[XLEN-1:OP_W] == {(XLEN-OP_W){wb_data[OP_W-1]}});

   // R9: returned half matches the updated accumulator
   a_r9_half_lo: assert property (@(posedge clk) disable iff (rst)
      (wb_en && !$past(instr[9])) |-> wb_data[OP_W-1:0] == acc[OP_W-1:0]);

   a_r9_half_hi: assert property (@(posedge clk) disable iff (rst)
      (wb_en && $past(instr[9])) |-> wb_data[OP_W-1:0] == acc[2*OP_W-1:OP_W]);

endmodule

bind mac_hilo_unit mac_hilo_chk #(
   .XLEN (XLEN),
   .OP_W (OP_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .instr    (instr),
   .wb_idx   (wb_idx),
   .wb_data  (wb_data),
   .wb_en    (wb_en),
   .illegal  (illegal),
   .acc      (acc_q)
);

// File: tb/mac_hilo_unit_tb.sv
module mac_hilo_unit_tb;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [31:0] instr;
   logic [31:0] rs_val;
   logic [31:0] rt_val;
   logic [4:0]  wb_idx;
   logic [63:0] wb_data;
   logic        wb_en;
   logic        illegal;

   int checks = 0;
   int errors = 0;
   logic [63:0] model_acc;

   localparam int F_LOAD = 0, F_NEG = 1, F_ADD = 2, F_SUB = 3;

   always #5 clk = ~clk;

   mac_hilo_unit u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
      .rs_val(rs_val), .rt_val(rt_val), .wb_idx(wb_idx),
      .wb_data(wb_data), .wb_en(wb_en), .illegal(illegal)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Encodings per R5..R8: sub codes, bit 3 = high half; function family, bit 0 = unsigned
   function automatic logic [31:0] enc(input int form, input bit sgn, input bit hi,
                                       input logic [4:0] rd);
      logic [4:0] sub;
      logic [5:0] fn;
      case (form)
         F_LOAD:  sub = 5'b00001;
         F_NEG:   sub = 5'b00011;
         F_ADD:   sub = 5'b00010;
         default: sub = 5'b00111;
      endcase
      sub[3] = hi;
      fn = (form == F_ADD) ? 6'b101000 : 6'b011000;
      fn[0] = ~sgn;
      return {6'b000000, 5'd3, 5'd4, rd, sub, fn};
   endfunction

   task automatic do_op(input string req, input int form, input bit sgn, input bit hi,
                        input logic [4:0] rd, input logic [31:0] a, input logic [31:0] b);
      logic [63:0] ea, eb, p;
      logic [31:0] h;
      ea = sgn ? {{32{a[31]}}, a} : {32'b0, a};
      eb = sgn ? {{32{b[31]}}, b} : {32'b0, b};
      p  = ea * eb;
      case (form)
         F_LOAD:  model_acc = p;
         F_NEG:   model_acc = 64'd0 - p;
         F_ADD:   model_acc = model_acc + p;
         default: model_acc = model_acc - p;
      endcase
      h = hi ? model_acc[63:32] : model_acc[31:0];
      @(negedge clk);
      in_valid = 1'b1;
      instr    = enc(form, sgn, hi, rd);
      rs_val   = a;
      rt_val   = b;
      @(posedge clk);
      #1;
      chk({req, " wb_en"},   64'(wb_en),   64'd1);
      chk({req, " illegal"}, 64'(illegal), 64'd0);
      chk({req, " wb_idx"},  64'(wb_idx),  64'(rd));
      chk({req, " wb_data"}, wb_data, {{32{h[31]}}, h});
   endtask

   task automatic do_bad(input string req, input logic [31:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      instr    = w;
      rs_val   = 32'h1234_5678;
      rt_val   = 32'h0000_0100;
      @(posedge clk);
      #1;
      chk({req, " illegal"}, 64'(illegal), 64'd1);
      chk({req, " wb_en"},   64'(wb_en),   64'd0);
   endtask

   task automatic go_idle(input string req);
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
      #1;
      chk({req, " wb_en"},   64'(wb_en),   64'd0);
      chk({req, " illegal"}, 64'(illegal), 64'd0);
   endtask

   // Read back both halves without disturbing them (add zero product)
   task automatic probe(input string req);
      do_op({req, " probe lo"}, F_ADD, 1'b1, 1'b0, 5'd30, 32'd0, 32'd0);
      do_op({req, " probe hi"}, F_ADD, 1'b1, 1'b1, 5'd31, 32'd0, 32'd0);
   endtask

   task automatic t_reset();
      rst = 1'b1; in_valid = 1'b0; instr = '0; rs_val = '0; rt_val = '0;
      model_acc = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R1 wb_en after reset",   64'(wb_en),   64'd0);
      chk("R1 illegal after reset", 64'(illegal), 64'd0);
      probe("R1");
   endtask

   task automatic t_load();
      do_op("R5 R3 load signed lo",   F_LOAD, 1'b1, 1'b0, 5'd1, 32'hFFFF_FFFE, 32'd3);
      do_op("R5 R3 load signed hi",   F_LOAD, 1'b1, 1'b1, 5'd2, 32'hFFFF_FFFE, 32'd3);
      do_op("R5 R4 load unsigned hi", F_LOAD, 1'b0, 1'b1, 5'd3, 32'hFFFF_FFFE, 32'd3);
      do_op("R5 R4 load unsigned lo", F_LOAD, 1'b0, 1'b0, 5'd4, 32'h8000_0000, 32'h8000_0000);
      do_op("R5 R3 load signed min",  F_LOAD, 1'b1, 1'b1, 5'd5, 32'h8000_0000, 32'h8000_0000);
   endtask

   task automatic t_neg();
      do_op("R6 neg signed lo",   F_NEG, 1'b1, 1'b0, 5'd6, 32'd7, 32'hFFFF_FFF9);
      do_op("R6 neg signed hi",   F_NEG, 1'b1, 1'b1, 5'd7, 32'h0001_0000, 32'h0003_0000);
      do_op("R6 neg unsigned hi", F_NEG, 1'b0, 1'b1, 5'd8, 32'hFFFF_FFFF, 32'd2);
      do_op("R6 neg zero",        F_NEG, 1'b0, 1'b0, 5'd9, 32'd0, 32'hDEAD_BEEF);
   endtask

   task automatic t_accumulate();
      do_op("R7 base load",         F_LOAD, 1'b1, 1'b0, 5'd10, 32'd100, 32'd100);
      do_op("R7 R12 add signed lo", F_ADD,  1'b1, 1'b0, 5'd11, 32'hFFFF_FFFF, 32'd50);
      do_op("R7 R12 add unsigned hi", F_ADD, 1'b0, 1'b1, 5'd12, 32'hFFFF_FFFF, 32'd50);
      do_op("R7 R9 add signed hi",  F_ADD,  1'b1, 1'b1, 5'd13, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
   endtask

   task automatic t_subtract();
      do_op("R8 base load",           F_LOAD, 1'b0, 1'b0, 5'd14, 32'd5, 32'd5);
      do_op("R8 sub signed lo",       F_SUB,  1'b1, 1'b0, 5'd15, 32'd3, 32'd3);
      do_op("R8 sub signed borrow",   F_SUB,  1'b1, 1'b1, 5'd16, 32'd4, 32'd10);
      do_op("R8 sub unsigned lo",     F_SUB,  1'b0, 1'b0, 5'd17, 32'hFFFF_FFFF, 32'd1);
      do_op("R8 sub signed neg prod", F_SUB,  1'b1, 1'b1, 5'd18, 32'hFFFF_FFFF, 32'd9);
   endtask

   task automatic t_wrap();
      do_op("R10 load big",      F_LOAD, 1'b0, 1'b1, 5'd19, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      do_op("R10 add wraps hi",  F_ADD,  1'b0, 1'b1, 5'd20, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      do_op("R10 add wraps lo",  F_ADD,  1'b0, 1'b0, 5'd21, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      do_op("R10 load zero",     F_LOAD, 1'b1, 1'b0, 5'd22, 32'd0, 32'd0);
      do_op("R10 sub below zero", F_SUB, 1'b0, 1'b1, 5'd23, 32'd1, 32'd1);
   endtask

   task automatic t_illegal();
      do_op("R11 base load", F_LOAD, 1'b1, 1'b1, 5'd24, 32'h1357_9BDF, 32'h0246_8ACE);
      do_bad("R11 nonzero opcode", {6'b000001, 5'd1, 5'd2, 5'd3, 5'b00011, 6'b011000});
      do_bad("R11 add sub with mul func", {6'b0, 5'd1, 5'd2, 5'd3, 5'b00010, 6'b011000});
      do_bad("R11 neg sub with mac func", {6'b0, 5'd1, 5'd2, 5'd3, 5'b00011, 6'b101000});
      do_bad("R11 sub bit4 set", {6'b0, 5'd1, 5'd2, 5'd3, 5'b10011, 6'b011000});
      do_bad("R11 unknown func", {6'b0, 5'd1, 5'd2, 5'd3, 5'b00001, 6'b011010});
      probe("R11 unchanged");
   endtask

   task automatic t_idle();
      go_idle("R12 idle");
      go_idle("R12 idle again");
      probe("R12 acc after idle");
   endtask

   initial begin
      t_reset();
      t_load();
      t_neg();
      t_accumulate();
      t_subtract();
      t_wrap();
      t_illegal();
      t_idle();
      @(negedge clk);
      in_valid = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule